// File: doc/BRIEF.md
# Multichannel DAC Staging and Update Controller

This block sits between a host request port and the frame serializer of a 32-channel, 16-bit streaming DAC. The host writes channel values into a staging store. It writes them one channel per access, or as packed words that cover a whole channel group. At every frame strobe the block copies the chosen staged values into an active store. The active store drives the serializer through a flat output bus. A channel is either free-running or held. A free channel takes its staged value at the next frame strobe. A held channel keeps its active value until the host sets its bit in a self-clearing update mask. That lets several held channels change together on one frame edge.

The block also holds a four-bit configuration register, whose bits go straight out as control lines, and an eight-bit LED register. It keeps a sticky error flag for misaligned group writes. A request with address bit 7 set is a read, and the data comes back one cycle later on a response port. The group size is fixed at build time by `LOG2_GRP`. A group covers 2^LOG2_GRP channels and every channel write is a group write of that size. The reset input is asynchronous and active low. The parent must release it synchronously to `clk`.

Top module: `dac_stage_ctrl`

## Requirements
- R1: After reset every active channel reads 0x8000 on `dac_out`. Staged values, hold mask, update mask, configuration, LEDs, error flag and `rsp_vld` are all zero.
- R2: A channel write only changes the staged value. A channel that is not held loads its staged value into the active store on the clock edge where `frame_stb` is high. That edge uses the staged value from before any write made in the same cycle.
- R3: Address 0x21 writes the hold mask, with bit n belonging to channel n. While bit n is set, frame strobes leave channel n's active value unchanged unless its update bit is set.
- R4: Address 0x20 writes the update mask. A held channel whose update bit is set loads its staged value at the next frame strobe. The mask is cleared on that strobe's edge. If the mask is written in a strobe cycle, the new value is kept for the following strobe.
- R5: A group write to base channel b, with the low LOG2_GRP bits of b zero, stages channels b to b+2^LOG2_GRP-1. Data word j of `req_data` (bits 32j+31:32j) carries channel b+2j in bits 15:0 and channel b+2j+1 in bits 31:16.
- R6: If `req_words` is smaller than the number of words in a group, the channels of the missing words are staged as zero.
- R7: A group write whose base channel has any of its low LOG2_GRP bits set changes no staged value and sets the sticky error flag `err_o`.
- R8: Address 0x22 writes the configuration register. Bit 0 drives `link_rst_o`, bit 1 drives `afe_pd_o`, bit 2 drives `dac_clr_o` and bit 3 drives `err_clr_o`. Address 0x23 bits 7:0 drive `led_o`. Writes to addresses 0x24 to 0x7F have no effect.
- R9: While `dac_clr_o` is high, every active channel is forced to 0x8000 from the next edge on, and frame strobes load nothing. The update mask is still cleared by those strobes.
- R10: While `err_clr_o` is high, `err_o` is cleared on the next edge and kept low, even if a misaligned write arrives at the same time.
- R11: A request with address bit 7 set changes no state. It raises `rsp_vld` for one cycle on the next edge. `rsp_data` then holds one of: the staged value of the channel, zero-extended, for addresses 0 to 31; the update mask, hold mask, configuration or LED value for 0x20 to 0x23; or zero for any other address. `rsp_data` keeps its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request valid for one cycle |
| req_addr | input | 8 | Register address; bit 7 selects a read |
| req_data | input | 32*WORDS | Write data; packed channel words for group writes |
| req_words | input | clog2(WORDS+1) | Number of valid 32-bit words in a group write |
| frame_stb | input | 1 | Frame boundary strobe |
| dac_out | output | 16*NUM_CH | Active channel values, channel n in bits 16n+15:16n |
| link_rst_o | output | 1 | Serial clock domain reset control |
| afe_pd_o | output | 1 | Analog front end power-down |
| dac_clr_o | output | 1 | Clear line to all DACs |
| err_clr_o | output | 1 | Error counter clear |
| led_o | output | 8 | User LED drive |
| err_o | output | 1 | Sticky misaligned-group-write flag |
| rsp_vld | output | 1 | Read response valid |
| rsp_data | output | 32 | Read response data |

## Verification
The bench builds the block with 32 channels and LOG2_GRP = 2. Each group therefore has four channels carried in two data words. That makes real misalignment possible at base offsets 1 to 3, and it makes short writes of one word and of zero words meaningful. With these values the bench can exercise the packing order, the zero fill, the error path and the hold and update interplay across group boundaries, all under a behavioural model. The case LOG2_GRP = 0, with one channel per access and no alignment rule, is not in this build.

// File: rtl/dac_stage_pkg.sv
package dac_stage_pkg;
  localparam int ADDR_W = 8;
  localparam int REG_W  = 32;
  localparam int CH_W   = 16;
  localparam int CFG_W  = 4;
  localparam int LED_W  = 8;
  localparam logic [CH_W-1:0] MID_CODE = 16'h8000;
  localparam logic [6:0] A_UPD  = 7'h20;
  localparam logic [6:0] A_HOLD = 7'h21;
  localparam logic [6:0] A_CFG  = 7'h22;
  localparam logic [6:0] A_LED  = 7'h23;

  typedef struct packed {
    logic err_clr;   // bit 3
    logic dac_clr;   // bit 2
    logic afe_pd;    // bit 1
    logic link_rst;  // bit 0
  } cfg_t;
endpackage

// File: rtl/dac_stage_wr_dec.sv
module dac_stage_wr_dec
  import dac_stage_pkg::*;
#(
  parameter int NUM_CH   = 32,
  parameter int LOG2_GRP = 2,
  localparam int GRP_CH  = 1 << LOG2_GRP,
  localparam int WORDS   = (GRP_CH + 1) / 2,
  localparam int DATA_W  = 32 * WORDS,
  localparam int WCW     = $clog2(WORDS + 1)
) (
  input  logic                   req_vld,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [DATA_W-1:0]      req_data,
  input  logic [WCW-1:0]         req_words,
  output logic [NUM_CH-1:0]      stg_we,
  output logic [NUM_CH*CH_W-1:0] stg_val,
  output logic                   upd_we,
  output logic                   hold_we,
  output logic                   cfg_we,
  output logic                   led_we,
  output logic                   bad_grp,
  output logic                   rd_req
);
  logic       is_wr;
  logic [6:0] a7;
  logic       in_ch;
  logic       aligned;
  logic       grp_ok;
  logic [6:0] grp_sel;

  assign a7      = req_addr[6:0];
  assign is_wr   = req_vld & ~req_addr[7];
  assign rd_req  = req_vld &  req_addr[7];
  assign in_ch   = (int'(a7) < NUM_CH);
  assign grp_sel = a7 >> LOG2_GRP;

  generate
    if (LOG2_GRP == 0) begin : g_align_single
      assign aligned = 1'b1;
    end else begin : g_align_grp
      assign aligned = (a7[LOG2_GRP-1:0] == '0);
    end
  endgenerate

  assign grp_ok  = is_wr & in_ch & aligned;
  assign bad_grp = is_wr & in_ch & ~aligned;

  assign upd_we  = is_wr & (a7 == A_UPD);
  assign hold_we = is_wr & (a7 == A_HOLD);
  assign cfg_we  = is_wr & (a7 == A_CFG);
  assign led_we  = is_wr & (a7 == A_LED);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    localparam int OFF = c % GRP_CH;
    localparam int WIX = OFF / 2;
    logic present;
    if (LOG2_GRP == 0) begin : g_full
      assign present = 1'b1;
    end else begin : g_cnt
      assign present = (int'(req_words) > WIX);
    end
    assign stg_we[c] = grp_ok & (grp_sel == 7'(c / GRP_CH));
    assign stg_val[c*CH_W +: CH_W] = present ? req_data[OFF*CH_W +: CH_W] : '0;
  end
endmodule

// File: rtl/dac_ctrl_regs.sv
module dac_ctrl_regs
  import dac_stage_pkg::*;
#(
  parameter int NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic              upd_we,
  input  logic              hold_we,
  input  logic              cfg_we,
  input  logic              led_we,
  input  logic              bad_grp,
  input  logic [NUM_CH-1:0] wmask,
  input  logic [CFG_W-1:0]  wcfg,
  input  logic [LED_W-1:0]  wled,
  output logic [NUM_CH-1:0] upd_q,
  output logic [NUM_CH-1:0] hold_q,
  output cfg_t              cfg_q,
  output logic [LED_W-1:0]  led_q,
  output logic              err_q
);
  logic [NUM_CH-1:0] upd_d;
  logic              upd_en;
  logic              err_d;
  logic              err_en;

  always_comb begin
    upd_d = upd_q;
    if (frame_stb) upd_d = '0;
    if (upd_we)    upd_d = wmask;
    upd_en = frame_stb | upd_we;
  end

  always_comb begin
    err_d = err_q | bad_grp;
    if (cfg_q.err_clr) err_d = 1'b0;
    err_en = bad_grp | cfg_q.err_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_q <= '0;
    end else if (upd_en) begin
      upd_q <= upd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (hold_we) begin
      hold_q <= wmask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_we) begin
      cfg_q <= cfg_t'(wcfg);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_q <= '0;
    end else if (led_we) begin
      led_q <= wled;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (err_en) begin
      err_q <= err_d;
    end
  end
endmodule

// File: rtl/dac_chan_store.sv
module dac_chan_store
  import dac_stage_pkg::*;
#(
  parameter int NUM_CH = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_stb,
  input  logic                   dac_clr,
  input  logic [NUM_CH-1:0]      hold_q,
  input  logic [NUM_CH-1:0]      upd_q,
  input  logic [NUM_CH-1:0]      stg_we,
  input  logic [NUM_CH*CH_W-1:0] stg_val,
  output logic [NUM_CH*CH_W-1:0] stg_q,
  output logic [NUM_CH*CH_W-1:0] act_q
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic            take;
    logic            act_en;
    logic [CH_W-1:0] act_d;

    always_comb begin
      take   = frame_stb & (~hold_q[c] | upd_q[c]);
      act_en = dac_clr | take;
      act_d  = dac_clr ? MID_CODE : stg_q[c*CH_W +: CH_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_q[c*CH_W +: CH_W] <= '0;
      end else if (stg_we[c]) begin
        stg_q[c*CH_W +: CH_W] <= stg_val[c*CH_W +: CH_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_q[c*CH_W +: CH_W] <= MID_CODE;
      end else if (act_en) begin
        act_q[c*CH_W +: CH_W] <= act_d;
      end
    end
  end
endmodule

// File: rtl/dac_rd_port.sv
module dac_rd_port
  import dac_stage_pkg::*;
#(
  parameter int NUM_CH = 32,
  localparam int CH_AW = $clog2(NUM_CH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_req,
  input  logic [6:0]             rd_addr,
  input  logic [NUM_CH*CH_W-1:0] stg_q,
  input  logic [NUM_CH-1:0]      upd_q,
  input  logic [NUM_CH-1:0]      hold_q,
  input  cfg_t                   cfg_q,
  input  logic [LED_W-1:0]       led_q,
  output logic                   rsp_vld,
  output logic [REG_W-1:0]       rsp_data
);
  logic [REG_W-1:0] sel_d;
  logic [CH_AW-1:0] idx;

  assign idx = rd_addr[CH_AW-1:0];

  always_comb begin
    sel_d = '0;
    if (int'(rd_addr) < NUM_CH) begin
      sel_d = REG_W'(stg_q[int'(idx)*CH_W +: CH_W]);
    end else begin
      case (rd_addr)
        A_UPD:   sel_d = REG_W'(upd_q);
        A_HOLD:  sel_d = REG_W'(hold_q);
        A_CFG:   sel_d = REG_W'(cfg_q);
        A_LED:   sel_d = REG_W'(led_q);
        default: sel_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld <= 1'b0;
    end else begin
      rsp_vld <= rd_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_data <= '0;
    end else if (rd_req) begin
      rsp_data <= sel_d;
    end
  end
endmodule

// File: rtl/dac_stage_ctrl.sv
module dac_stage_ctrl
  import dac_stage_pkg::*;
#(
  parameter int NUM_CH   = 32,
  parameter int LOG2_GRP = 2,
  localparam int GRP_CH  = 1 << LOG2_GRP,
  localparam int WORDS   = (GRP_CH + 1) / 2,
  localparam int DATA_W  = 32 * WORDS,
  localparam int WCW     = $clog2(WORDS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_vld,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [DATA_W-1:0]      req_data,
  input  logic [WCW-1:0]         req_words,
  input  logic                   frame_stb,
  output logic [NUM_CH*CH_W-1:0] dac_out,
  output logic                   link_rst_o,
  output logic                   afe_pd_o,
  output logic                   dac_clr_o,
  output logic                   err_clr_o,
  output logic [LED_W-1:0]       led_o,
  output logic                   err_o,
  output logic                   rsp_vld,
  output logic [REG_W-1:0]       rsp_data
);
  logic [NUM_CH-1:0]      stg_we;
  logic [NUM_CH*CH_W-1:0] stg_val;
  logic [NUM_CH*CH_W-1:0] stg_q;
  logic                   upd_we, hold_we, cfg_we, led_we;
  logic                   bad_grp, rd_req;
  logic [NUM_CH-1:0]      upd_q, hold_q;
  cfg_t                   cfg_q;

  dac_stage_wr_dec #(.NUM_CH(NUM_CH), .LOG2_GRP(LOG2_GRP)) u_dec (
    .req_vld  (req_vld),
    .req_addr (req_addr),
    .req_data (req_data),
    .req_words(req_words),
    .stg_we   (stg_we),
    .stg_val  (stg_val),
    .upd_we   (upd_we),
    .hold_we  (hold_we),
    .cfg_we   (cfg_we),
    .led_we   (led_we),
    .bad_grp  (bad_grp),
    .rd_req   (rd_req)
  );

  dac_ctrl_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_stb(frame_stb),
    .upd_we   (upd_we),
    .hold_we  (hold_we),
    .cfg_we   (cfg_we),
    .led_we   (led_we),
    .bad_grp  (bad_grp),
    .wmask    (req_data[NUM_CH-1:0]),
    .wcfg     (req_data[CFG_W-1:0]),
    .wled     (req_data[LED_W-1:0]),
    .upd_q    (upd_q),
    .hold_q   (hold_q),
    .cfg_q    (cfg_q),
    .led_q    (led_o),
    .err_q    (err_o)
  );

  dac_chan_store #(.NUM_CH(NUM_CH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_stb(frame_stb),
    .dac_clr  (cfg_q.dac_clr),
    .hold_q   (hold_q),
    .upd_q    (upd_q),
    .stg_we   (stg_we),
    .stg_val  (stg_val),
    .stg_q    (stg_q),
    .act_q    (dac_out)
  );

  dac_rd_port #(.NUM_CH(NUM_CH)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_req  (rd_req),
    .rd_addr (req_addr[6:0]),
    .stg_q   (stg_q),
    .upd_q   (upd_q),
    .hold_q  (hold_q),
    .cfg_q   (cfg_q),
    .led_q   (led_o),
    .rsp_vld (rsp_vld),
    .rsp_data(rsp_data)
  );

  assign link_rst_o = cfg_q.link_rst;
  assign afe_pd_o   = cfg_q.afe_pd;
  assign dac_clr_o  = cfg_q.dac_clr;
  assign err_clr_o  = cfg_q.err_clr;
endmodule

// File: rtl/dac_stage_ctrl_chk.sv
module dac_stage_ctrl_chk #(
  parameter int NUM_CH   = 32,
  parameter int LOG2_GRP = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_vld,
  input logic [7:0]           req_addr,
  input logic                 frame_stb,
  input logic [NUM_CH*16-1:0] dac_out,
  input logic                 dac_clr_o,
  input logic                 err_clr_o,
  input logic                 err_o,
  input logic                 rsp_vld,
  input logic [NUM_CH-1:0]    upd_q
);
  localparam logic [6:0] GMASK = 7'((1 << LOG2_GRP) - 1);

  logic is_rd, bad_wr, upd_wr;
  assign is_rd  = req_vld & req_addr[7];
  assign bad_wr = req_vld & ~req_addr[7] & (int'(req_addr[6:0]) < NUM_CH)
                  & ((req_addr[6:0] & GMASK) != 7'd0);
  assign upd_wr = req_vld & (req_addr == 8'h20);

  // R11
  rd_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd |=> rsp_vld);
  // R11
  no_rd_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_rd |=> !rsp_vld);
  // R9
  clr_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_clr_o |=> (dac_out == {NUM_CH{16'h8000}}));
  // R2
  quiet_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_stb && !dac_clr_o) |=> $stable(dac_out));
  // R7
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> $past(bad_wr));
  // R10
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr_o |=> !err_o);
  // R4
  upd_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && !upd_wr) |=> (upd_q == '0));
endmodule

bind dac_stage_ctrl dac_stage_ctrl_chk #(.NUM_CH(NUM_CH), .LOG2_GRP(LOG2_GRP)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_vld  (req_vld),
  .req_addr (req_addr),
  .frame_stb(frame_stb),
  .dac_out  (dac_out),
  .dac_clr_o(dac_clr_o),
  .err_clr_o(err_clr_o),
  .err_o    (err_o),
  .rsp_vld  (rsp_vld),
  .upd_q    (upd_q)
);

// File: tb/dac_stage_ctrl_tb.sv
module dac_stage_ctrl_tb;
  localparam int NCH = 32;
  localparam int LG  = 2;
  localparam int GC  = 1 << LG;
  localparam int NW  = (GC + 1) / 2;
  localparam int DW  = 32 * NW;
  localparam int WC  = $clog2(NW + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_vld = 1'b0;
  logic [7:0]        req_addr = '0;
  logic [DW-1:0]     req_data = '0;
  logic [WC-1:0]     req_words = '0;
  logic              frame_stb = 1'b0;
  logic [NCH*16-1:0] dac_out;
  logic              link_rst_o, afe_pd_o, dac_clr_o, err_clr_o, err_o, rsp_vld;
  logic [7:0]        led_o;
  logic [31:0]       rsp_data;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  dac_stage_ctrl #(.NUM_CH(NCH), .LOG2_GRP(LG)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_addr(req_addr),
    .req_data(req_data), .req_words(req_words), .frame_stb(frame_stb),
    .dac_out(dac_out), .link_rst_o(link_rst_o), .afe_pd_o(afe_pd_o),
    .dac_clr_o(dac_clr_o), .err_clr_o(err_clr_o), .led_o(led_o), .err_o(err_o),
    .rsp_vld(rsp_vld), .rsp_data(rsp_data)
  );

  // behavioural reference model
  int unsigned m_stg [NCH];
  int unsigned m_act [NCH];
  bit [31:0]   m_hold, m_upd, m_rd;
  bit [3:0]    m_cfg;
  bit [7:0]    m_led;
  bit          m_err, m_rv;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_stg[i]) begin m_stg[i] = 0; m_act[i] = 32'h8000; end
      m_hold = 0; m_upd = 0; m_cfg = 0; m_led = 0; m_err = 0; m_rv = 0; m_rd = 0;
    end else begin
      int unsigned n_stg [NCH];
      bit [31:0] n_upd, n_hold;
      bit [3:0] n_cfg;
      bit [7:0] n_led;
      bit n_err, bad;
      int a;
      a = int'(req_addr[6:0]);
      n_stg = m_stg; n_upd = m_upd; n_hold = m_hold; n_cfg = m_cfg; n_led = m_led;
      bad = 0;
      for (int c = 0; c < NCH; c++) begin
        if (m_cfg[2]) m_act[c] = 32'h8000;
        else if (frame_stb && (!m_hold[c] || m_upd[c])) m_act[c] = m_stg[c];
      end
      if (req_vld && req_addr[7]) begin
        m_rv = 1;
        if (a < NCH) m_rd = m_stg[a];
        else if (a == 32) m_rd = m_upd;
        else if (a == 33) m_rd = m_hold;
        else if (a == 34) m_rd = {28'd0, m_cfg};
        else if (a == 35) m_rd = {24'd0, m_led};
        else m_rd = 0;
      end else begin
        m_rv = 0;
      end
      if (frame_stb) n_upd = 0;
      if (req_vld && !req_addr[7]) begin
        if (a < NCH) begin
          if (a % GC != 0) bad = 1;
          else for (int j = 0; j < GC; j++)
            n_stg[a+j] = ((j / 2) < int'(req_words)) ? int'(req_data[j*16 +: 16]) : 0;
        end else if (a == 32) n_upd = req_data[31:0];
        else if (a == 33) n_hold = req_data[31:0];
        else if (a == 34) n_cfg = req_data[3:0];
        else if (a == 35) n_led = req_data[7:0];
      end
      n_err = m_err | bad;
      if (m_cfg[3]) n_err = 0;
      m_stg = n_stg; m_upd = n_upd; m_hold = n_hold; m_cfg = n_cfg;
      m_led = n_led; m_err = n_err;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < NCH; c++)
        chk($sformatf("R2 R3 R4 R9 active ch%0d", c), dac_out[c*16 +: 16], m_act[c]);
      chk("R8 cfg outputs", {err_clr_o, dac_clr_o, afe_pd_o, link_rst_o}, m_cfg);
      chk("R8 leds", led_o, m_led);
      chk("R7 R10 err flag", err_o, m_err);
      chk("R11 rsp_vld", rsp_vld, m_rv);
      chk("R11 rsp_data (staging R5 R6)", rsp_data, m_rd);
    end
  end

  task automatic cyc(input bit v, input bit [7:0] a, input logic [DW-1:0] d,
                     input int w, input bit f);
    @(negedge clk);
    req_vld = v; req_addr = a; req_data = d; req_words = WC'(w); frame_stb = f;
    @(posedge clk);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, '0, 0, 0);
  endtask
  task automatic rd(input bit [7:0] a);
    cyc(1, 8'h80 | a, '0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ch0 mid", dac_out[15:0], 16'h8000);
    chk("R1 ch31 mid", dac_out[NCH*16-1 -: 16], 16'h8000);
    chk("R1 err", err_o, 0);
    chk("R1 leds", led_o, 0);
    rd(8'h20); rd(8'h21); rd(8'h22); rd(8'h00); idle(1);
    // R5 full group at base 0, then frame (R2)
    cyc(1, 8'h00, 64'h4444_3333_2222_1111, 2, 0);
    rd(0); rd(1); rd(2); rd(3);
    cyc(0, 0, '0, 0, 1); idle(1);
    // R6 short groups
    cyc(1, 8'h04, 64'hAAAA_BBBB_5555_6666, 1, 0);
    cyc(1, 8'h08, 64'h1234_5678_9ABC_DEF0, 0, 0);
    rd(4); rd(5); rd(6); rd(7); rd(8); rd(11);
    // R7 misaligned write ignored, error set
    cyc(1, 8'h05, 64'hFFFF_FFFF_FFFF_FFFF, 2, 0);
    rd(5); rd(6); idle(1);
    cyc(1, 8'h0D, 64'h1, 2, 0); idle(1);
    // R10 clear errors, with a misaligned write during clear
    cyc(1, 8'h22, 64'h8, 0, 0);
    cyc(1, 8'h06, 64'h1, 2, 0); idle(2);
    cyc(1, 8'h22, 64'h0, 0, 0); idle(1);
    // R3 hold channels 4..7, stage new data, frame
    cyc(1, 8'h21, 64'h0000_00F0, 0, 0);
    cyc(1, 8'h04, 64'h7777_7777_C0DE_BEEF, 2, 1);
    cyc(0, 0, '0, 0, 1); idle(1);
    // R4 update ch4 only
    cyc(1, 8'h20, 64'h10, 0, 0);
    rd(8'h20);
    cyc(0, 0, '0, 0, 1);
    rd(8'h20); idle(1);
    // R4 update written in a strobe cycle survives to next strobe
    cyc(1, 8'h20, 64'hE0, 0, 1);
    rd(8'h20);
    cyc(0, 0, '0, 0, 1); idle(1);
    // R2 write in strobe cycle: old value taken
    cyc(1, 8'h10, 64'h0F0F_0E0E_0D0D_0C0C, 2, 1);
    idle(1); cyc(0, 0, '0, 0, 1); idle(1);
    // R9 DAC clear
    cyc(1, 8'h22, 64'h4, 0, 0);
    cyc(0, 0, '0, 0, 1); idle(2);
    cyc(1, 8'h22, 64'h0, 0, 0); idle(2);
    cyc(0, 0, '0, 0, 1); idle(1);
    // R8 cfg, LEDs, unmapped addresses; R11 reads
    cyc(1, 8'h23, 64'hA5, 0, 0);
    cyc(1, 8'h22, 64'h3, 0, 0);
    cyc(1, 8'h30, 64'hFF, 0, 0);
    cyc(1, 8'h7F, 64'hFF, 0, 0);
    rd(8'h22); rd(8'h23); rd(8'h24); rd(8'h7F); idle(1);
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      int s;
      bit [7:0] a;
      s = int'($urandom_range(0, 9));
      a = (s < 4) ? 8'($urandom_range(0, NCH-1)) : (s < 7) ? 8'(32 + (s - 4)) :
          (s == 7) ? 8'h22 : 8'($urandom_range(0, 255));
      if (a == 8'h22) a = ($urandom_range(0, 3) == 0) ? 8'h22 : 8'h21;
      cyc($urandom_range(0, 3) != 0, a, {$urandom, $urandom},
          int'($urandom_range(0, NW)), $urandom_range(0, 2) == 0);
    end
    idle(2);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule